// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches a single 16-bit word from a three-wire serial EEPROM. A host raises a one-cycle start request together with a 6-bit word address. The reader then drives chip select, the serial clock and the serial data line toward the memory, and collects the memory's serial output. When the word is assembled it comes back to the host with a one-cycle done pulse.

The serial clock is a divided copy of the system clock. A parameter sets how many system cycles make up each half-period, and a second parameter sets how long chip select is held before the first clock phase begins. Only the read command is produced. All memory lines rest low between transactions.

Top module: `mw_rom_reader`

## Requirements
- R1: While reset is asserted and right after it, romCs, romSk, romDi, busy and done are all 0 and wordOut is 0.
- R2: A transaction begins with romCs rising while romSk and romDi are 0. The first rising edge of romSk comes exactly SETUP_CYCLES + HALF_CYCLES system cycles after romCs rises.
- R3: The first three bits the memory latches on rising romSk edges are 1, 1, 0, in that order.
- R4: The next six rising edges carry the word address, most significant bit first.
- R5: romDi changes only while romSk is low. Every high phase of romSk lasts HALF_CYCLES system cycles, and so does every low phase between two rising edges.
- R6: One transaction issues exactly 26 rising romSk edges: 9 for the command and 17 for the read phase.
- R7: romDo is sampled once at the end of each of the 17 read-phase high phases. The sampled bits shift in from the least significant end, so the first one falls off and wordOut holds the last 16, the earliest kept bit being bit 15.
- R8: In the cycle done is high, romCs, romSk and romDi are all 0.
- R9: busy goes to 1 in the cycle after an accepted start request and returns to 0 in the done cycle. A start request seen while busy is 1 is ignored and launches no further transaction.
- R10: done is high for exactly one system cycle with the new word on wordOut. wordOut changes only in a done cycle and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request to read a word |
| wordAddr | input | ADDR_BITS | Word address, captured with an accepted start request |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| wordOut | output | DATA_BITS | Most recently read word |
| romCs | output | 1 | Chip select toward the memory |
| romSk | output | 1 | Serial clock toward the memory |
| romDi | output | 1 | Serial command/address toward the memory |
| romDo | input | 1 | Serial data from the memory |

## Verification
The bench builds the reader with HALF_CYCLES = 3 and SETUP_CYCLES = 5. A whole 26-edge transaction therefore fits in under 170 system cycles, so several reads, a read with an intruding start request and back-to-back reads all run in one short test. Because the two values differ, the chip-select gap of 8 cycles is a separate count from the half-period. A swap of the two parameters, or a lost setup phase, then shows up as a wrong gap. The memory model drives a 1 outside the data window and answers the dummy slot with 0, so a reader that keeps the wrong 16 of its 17 samples returns a word that differs from the expected one.

// File: rtl/mw_rom_pkg.sv
package mw_rom_pkg;

  // Strobes from the sequencer to the pin/shift datapath
  typedef struct packed {
    logic load;     // raise select, latch command word, clear capture
    logic setLow;   // drop clock and present next command bit
    logic setHigh;  // raise clock
    logic sample;   // shift data-out into the capture register
    logic finish;   // release all lines and publish the word
  } romStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } romState_t;

endpackage

// File: rtl/mw_rom_ctrl.sv
module mw_rom_ctrl
  import mw_rom_pkg::*;
#(
  parameter int HALF_CYCLES  = 100,
  parameter int SETUP_CYCLES = 25,
  parameter int CMD_BITS     = 9,
  parameter int READ_BITS    = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output logic       busy,
  output romStrobe_t strobe
);

  localparam int TOTAL_BITS = CMD_BITS + READ_BITS;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam int TMR_MAX    = (HALF_CYCLES > SETUP_CYCLES) ? HALF_CYCLES : SETUP_CYCLES;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] HALF_LOAD  = TMR_W'(HALF_CYCLES - 1);
  localparam logic [TMR_W-1:0] SETUP_LOAD = TMR_W'(SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_READ = CNT_W'(CMD_BITS);

  romState_t        state, nextState;
  logic [TMR_W-1:0] timer, nextTimer;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             timerZero;

  assign timerZero = (timer == '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    nextTimer = timer;
    nextCnt   = bitCnt;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          nextState   = ST_SETUP;
          nextTimer   = SETUP_LOAD;
          nextCnt     = '0;
        end
      end
      ST_SETUP: begin
        if (timerZero) begin
          strobe.setLow = 1'b1;
          nextState     = ST_LOW;
          nextTimer     = HALF_LOAD;
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_LOW: begin
        if (timerZero) begin
          strobe.setHigh = 1'b1;
          nextState      = ST_HIGH;
          nextTimer      = HALF_LOAD;
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_HIGH: begin
        if (timerZero) begin
          strobe.sample = (bitCnt >= FIRST_READ);
          if (bitCnt == LAST_BIT) begin
            strobe.finish = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            strobe.setLow = 1'b1;
            nextState     = ST_LOW;
            nextTimer     = HALF_LOAD;
            nextCnt       = bitCnt + 1'b1;
          end
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      timer  <= nextTimer;
      bitCnt <= nextCnt;
    end
  end

endmodule

// File: rtl/mw_rom_dp.sv
module mw_rom_dp
  import mw_rom_pkg::*;
#(
  parameter int ADDR_BITS   = 6,
  parameter int DATA_BITS   = 16,
  parameter int OPCODE_BITS = 3,
  parameter logic [OPCODE_BITS-1:0] OPCODE = 3'b110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  romStrobe_t           strobe,
  input  logic [ADDR_BITS-1:0] wordAddr,
  input  logic                 romDo,
  output logic                 romCs,
  output logic                 romSk,
  output logic                 romDi,
  output logic                 done,
  output logic [DATA_BITS-1:0] wordOut
);

  localparam int CMD_BITS = OPCODE_BITS + ADDR_BITS;

  logic [CMD_BITS-1:0]  cmdShift;
  logic [DATA_BITS-1:0] capture;
  logic [DATA_BITS-1:0] nextCap;

  // New bits enter at the bottom; a 17th sample pushes the dummy out the top
  assign nextCap = {capture[DATA_BITS-2:0], romDo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romCs    <= 1'b0;
      romSk    <= 1'b0;
      romDi    <= 1'b0;
      done     <= 1'b0;
      cmdShift <= '0;
      capture  <= '0;
      wordOut  <= '0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        romCs    <= 1'b1;
        romSk    <= 1'b0;
        romDi    <= 1'b0;
        cmdShift <= {OPCODE, wordAddr};
        capture  <= '0;
      end
      if (strobe.setLow) begin
        romSk    <= 1'b0;
        romDi    <= cmdShift[CMD_BITS-1];
        cmdShift <= {cmdShift[CMD_BITS-2:0], 1'b0};
      end
      if (strobe.setHigh) begin
        romSk <= 1'b1;
      end
      if (strobe.sample) begin
        capture <= nextCap;
      end
      if (strobe.finish) begin
        romCs   <= 1'b0;
        romSk   <= 1'b0;
        romDi   <= 1'b0;
        wordOut <= nextCap;
      end
    end
  end

endmodule

// File: rtl/mw_rom_reader.sv
module mw_rom_reader
  import mw_rom_pkg::*;
#(
  parameter int ADDR_BITS    = 6,
  parameter int DATA_BITS    = 16,
  parameter int HALF_CYCLES  = 100,
  parameter int SETUP_CYCLES = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [ADDR_BITS-1:0] wordAddr,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 romCs,
  output logic                 romSk,
  output logic                 romDi,
  input  logic                 romDo
);

  localparam int OPCODE_BITS = 3;
  localparam logic [OPCODE_BITS-1:0] READ_OPCODE = 3'b110;
  localparam int CMD_BITS  = OPCODE_BITS + ADDR_BITS;
  localparam int READ_BITS = DATA_BITS + 1;

  romStrobe_t strobe;

  mw_rom_ctrl #(
    .HALF_CYCLES (HALF_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES),
    .CMD_BITS    (CMD_BITS),
    .READ_BITS   (READ_BITS)
  ) ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .busy    (busy),
    .strobe  (strobe)
  );

  mw_rom_dp #(
    .ADDR_BITS  (ADDR_BITS),
    .DATA_BITS  (DATA_BITS),
    .OPCODE_BITS(OPCODE_BITS),
    .OPCODE     (READ_OPCODE)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wordAddr(wordAddr),
    .romDo   (romDo),
    .romCs   (romCs),
    .romSk   (romSk),
    .romDi   (romDi),
    .done    (done),
    .wordOut (wordOut)
  );

endmodule

// File: rtl/mw_rom_reader_chk.sv
module mw_rom_reader_chk #(
  parameter int DATA_BITS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 done,
  input logic [DATA_BITS-1:0] wordOut,
  input logic                 romCs,
  input logic                 romSk,
  input logic                 romDi
);

  // R2
  cs_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCs) |-> (!romSk && !romDi));

  // R5
  di_moves_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(romDi) |-> !romSk);

  // R8
  end_lines_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!romCs && !romSk && !romDi));

  // R9
  busy_clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  clock_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    romSk |-> (busy && romCs));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> done);

endmodule

bind mw_rom_reader mw_rom_reader_chk #(.DATA_BITS(DATA_BITS)) chkInst (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .wordOut(wordOut),
  .romCs  (romCs),
  .romSk  (romSk),
  .romDi  (romDi)
);

// File: tb/mw_rom_reader_test.sv
module mw_rom_reader_test;

  localparam int HALF  = 3;
  localparam int SETUP = 5;

  typedef struct packed {
    logic [5:0]  addr;
    logic [15:0] data;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [5:0]  wordAddr = '0;
  logic        busy, done, romCs, romSk, romDi;
  logic [15:0] wordOut;
  logic        romDo = 1'b1;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  mw_rom_reader #(
    .ADDR_BITS(6), .DATA_BITS(16), .HALF_CYCLES(HALF), .SETUP_CYCLES(SETUP)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordAddr(wordAddr),
    .busy(busy), .done(done), .wordOut(wordOut),
    .romCs(romCs), .romSk(romSk), .romDi(romDi), .romDo(romDo)
  );

  function automatic logic [15:0] memWord(input logic [5:0] a);
    return {a, ~a[3:0], a} ^ 16'h9C3A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: latches romDi on rising romSk, answers after the command
  int         skRises = 0;
  logic [2:0] gotOp = '0;
  logic [5:0] gotAddr = '0;
  always @(posedge romSk or posedge romCs) begin
    if (!romSk) begin
      skRises <= 0;
      romDo   <= 1'b1;
    end else begin
      automatic int n = skRises + 1;
      automatic logic [15:0] w = memWord(gotAddr);
      if (n <= 3) gotOp <= {gotOp[1:0], romDi};
      else if (n <= 9) gotAddr <= {gotAddr[4:0], romDi};
      if (n == 10) romDo <= 1'b0;
      else if (n >= 11 && n <= 26) romDo <= w[26 - n];
      else romDo <= 1'b1;
      skRises <= n;
    end
  end

  // Monitor: timing bookkeeping and scoreboard compare
  logic prevSk = 1'b0, prevCs = 1'b0, prevDi = 1'b0, prevDone = 1'b0;
  int   lvlCnt = 0, gapCnt = 0, gapVal = 0;
  bit   riseSeen = 0, badHigh = 0, badLow = 0, diBad = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (romCs && !prevCs) begin
        gapCnt = 0; riseSeen = 0; badHigh = 0; badLow = 0; diBad = 0;
      end else if (romCs && !riseSeen) begin
        gapCnt++;
      end
      if (romSk != prevSk) begin
        if (prevSk) begin
          if (lvlCnt != HALF) badHigh = 1;
        end else begin
          if (riseSeen && lvlCnt != HALF) badLow = 1;
          if (!riseSeen) gapVal = gapCnt;
          riseSeen = 1;
        end
        lvlCnt = 1;
      end else begin
        lvlCnt++;
      end
      if (romDi != prevDi && romSk) diBad = 1;
      if (done && prevDone) check(0, "R10 done longer than one cycle", 2, 1);
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R9 completion without accepted request", 1, 0);
        end else begin
          automatic expItem_t e = expQ.pop_front();
          check(wordOut == e.data, "R7 word value", wordOut, e.data);
          check(skRises == 26, "R6 rising edge count", skRises, 26);
          check(gotOp == 3'b110, "R3 opcode bits", gotOp, 3'b110);
          check(gotAddr == e.addr, "R4 address bits", gotAddr, e.addr);
          check(!romCs && !romSk && !romDi, "R8 lines low at done",
                {romCs, romSk, romDi}, 0);
          check(gapVal == SETUP + HALF, "R2 select to first clock gap", gapVal,
                SETUP + HALF);
          check(!badHigh && !badLow && !diBad, "R5 phase widths and data timing",
                {badHigh, badLow, diBad}, 0);
          check(!busy, "R9 busy low at done", busy, 0);
        end
      end
      prevSk = romSk; prevCs = romCs; prevDi = romDi; prevDone = done;
    end
  end

  // Driver
  task automatic launch(input logic [5:0] a);
    @(negedge clk);
    startReq = 1'b1;
    wordAddr = a;
    expQ.push_back('{addr: a, data: memWord(a)});
    @(negedge clk);
    startReq = 1'b0;
    wordAddr = ~a;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({romCs, romSk, romDi, busy, done} == 5'b0 && wordOut == 16'h0,
          "R1 reset outputs", {romCs, romSk, romDi, busy, done, wordOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({romCs, romSk, romDi, busy, done} == 5'b0 && wordOut == 16'h0,
          "R1 outputs after reset release", {romCs, romSk, romDi, busy, done}, 0);

    // R3 R4 R7 several addresses
    launch(6'h00); waitDone();
    launch(6'h3F); waitDone();
    launch(6'h2A); waitDone();

    // R9 start while busy is ignored
    launch(6'h15);
    repeat (30) @(negedge clk);
    startReq = 1'b1; wordAddr = 6'h33;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    repeat (10) @(negedge clk);
    check(!busy && !romCs, "R9 no transaction from ignored start", {busy, romCs}, 0);
    // R10 result holds while idle
    check(wordOut == memWord(6'h15), "R10 word held after done", wordOut,
          memWord(6'h15));

    // back-to-back reads, start in cycle after done
    launch(6'h01); waitDone();
    launch(6'h20); waitDone();
    repeat (5) @(negedge clk);
    check(wordOut == memWord(6'h20), "R10 word held at end", wordOut, memWord(6'h20));
    check(expQ.size() == 0, "R7 all expected words seen", expQ.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule